// File: doc/BRIEF.md
# Timer Compare Output Channel

This block is one compare channel of a general-purpose timer. It takes the running count of a shared timebase and compares it, every clock, with the channel's compare value. The result drives a reference waveform under the control of a 3-bit run-time mode, and a one-clock match pulse each time the count equals the compare value. The channel can hold its output frozen, set it, clear it or toggle it on a match, force it low or high, or run as a pulse-width modulator in either polarity.

The compare value is written through a write strobe. When preload is off, a write takes effect at the next clock. When preload is on, the write lands in a holding register and reaches the comparator only at the next timebase update event. This keeps a running PWM period from being cut short by a mid-period write. The channel also keeps a 2-bit direction select, which marks it as an output or as one of three input routings. That select can only be changed while the channel enable is low.

Top module: `ocx_channel`

## Requirements
- R1: With mode 3'b000, the reference output keeps its value whatever the count does.
- R2: With mode 3'b001, the reference output goes high on the clock after the count equals the active compare value, and otherwise keeps its value.
- R3: With mode 3'b010, the reference output goes low on the clock after the count equals the active compare value, and otherwise keeps its value.
- R4: With mode 3'b011, the reference output inverts on the clock after each cycle in which the count equals the active compare value.
- R5: With mode 3'b100, the reference output is low on the next clock; with mode 3'b101 it is high on the next clock, regardless of the count.
- R6: With mode 3'b110, the reference output on the next clock is high if the count is below the active compare value, and low otherwise.
- R7: With mode 3'b111, the reference output on the next clock is low if the count is below the active compare value, and high otherwise.
- R8: With preload off, a compare write becomes the active compare value on the next clock. With preload on, it is held, and it becomes active on the clock of an update event. A write and an update in the same cycle make the written value active at once.
- R9: The match output is high for exactly the clock following a cycle in which the count equals the active compare value, in every mode.
- R10: The 2-bit select (00 output, 01 direct input, 10 crossed input, 11 trigger input) takes the written value on the next clock only when the channel enable is 0. A write while the enable is 1 leaves it unchanged.
- R11: After reset, the reference output, the match output, the select and both compare registers are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cnt_i | input | W | Timebase count |
| upd_i | input | 1 | Timebase update event |
| cmp_wr_i | input | 1 | Compare value write strobe |
| cmp_wdata_i | input | W | Compare value to write |
| preload_i | input | 1 | Preload (double buffering) enable |
| mode_i | input | 3 | Reference mode |
| chan_en_i | input | 1 | Channel enable, locks the select |
| sel_wr_i | input | 1 | Select write strobe |
| sel_wdata_i | input | 2 | Select value to write |
| ref_o | output | 1 | Reference waveform |
| match_o | output | 1 | One-clock match pulse |
| sel_o | output | 2 | Current direction select |

## Verification
The assertions check on every cycle the cases that depend only on one cycle's inputs. These are the forced levels, the frozen hold, the PWM level against the active compare value, the match pulse, the immediate write path and the select lock. Set, clear and toggle depend on the history of the reference. The deferral of a preloaded write until an update, and the way a buffered value later moves the PWM edge, also depend on history. The bench's reference model and its directed preload scenarios are what show those.

// File: rtl/ocx_pkg.sv
package ocx_pkg;

  typedef enum logic [2:0] {
    OCM_FROZEN   = 3'b000,
    OCM_SET_HI   = 3'b001,
    OCM_SET_LO   = 3'b010,
    OCM_TOGGLE   = 3'b011,
    OCM_FORCE_LO = 3'b100,
    OCM_FORCE_HI = 3'b101,
    OCM_PWM_A    = 3'b110,
    OCM_PWM_B    = 3'b111
  } ocm_e;

  typedef enum logic [1:0] {
    SEL_OUT       = 2'b00,
    SEL_IN_DIRECT = 2'b01,
    SEL_IN_CROSS  = 2'b10,
    SEL_IN_TRIG   = 2'b11
  } chsel_e;

endpackage

// File: rtl/ocx_cmp_shadow.sv
// Compare value storage: holding register plus active register.
module ocx_cmp_shadow #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         preload_i,
  input  logic         upd_i,
  output logic [W-1:0] active_o
);

  logic [W-1:0] hold_q, hold_d;
  logic [W-1:0] act_q, act_d;
  logic         hold_en, act_en;

  always_comb begin
    hold_en = wr_i;
    hold_d  = wdata_i;
    act_en  = 1'b0;
    act_d   = act_q;
    if (!preload_i) begin
      act_en = wr_i;
      act_d  = wdata_i;
    end else if (upd_i) begin
      act_en = 1'b1;
      act_d  = wr_i ? wdata_i : hold_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      act_q  <= '0;
    end else begin
      if (hold_en) hold_q <= hold_d;
      if (act_en)  act_q  <= act_d;
    end
  end

  assign active_o = act_q;

endmodule

// File: rtl/ocx_ref_gen.sv
// Comparator and reference waveform generator.
module ocx_ref_gen
  import ocx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_i,
  input  logic [W-1:0] cmp_i,
  input  ocm_e         mode_i,
  output logic         ref_o,
  output logic         match_o
);

  logic eq, below;
  logic ref_q, ref_d;
  logic match_q;

  assign eq    = (cnt_i == cmp_i);
  assign below = (cnt_i <  cmp_i);

  always_comb begin
    ref_d = ref_q;
    unique case (mode_i)
      OCM_FROZEN:   ref_d = ref_q;
      OCM_SET_HI:   if (eq) ref_d = 1'b1;
      OCM_SET_LO:   if (eq) ref_d = 1'b0;
      OCM_TOGGLE:   if (eq) ref_d = ~ref_q;
      OCM_FORCE_LO: ref_d = 1'b0;
      OCM_FORCE_HI: ref_d = 1'b1;
      OCM_PWM_A:    ref_d = below;
      OCM_PWM_B:    ref_d = ~below;
      default:      ref_d = ref_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ref_q   <= 1'b0;
      match_q <= 1'b0;
    end else begin
      ref_q   <= ref_d;
      match_q <= eq;
    end
  end

  assign ref_o   = ref_q;
  assign match_o = match_q;

endmodule

// File: rtl/ocx_sel_lock.sv
// Direction select, writable only while the channel is disabled.
module ocx_sel_lock
  import ocx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       chan_en_i,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  output chsel_e     sel_o
);

  chsel_e sel_q, sel_d;
  logic   sel_en;

  always_comb begin
    sel_en = wr_i && !chan_en_i;
    sel_d  = chsel_e'(wdata_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      sel_q <= SEL_OUT;
    else if (sel_en) sel_q <= sel_d;
  end

  assign sel_o = sel_q;

endmodule

// File: rtl/ocx_channel.sv
module ocx_channel
  import ocx_pkg::*;
#(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] cnt_i,
  input  logic         upd_i,
  input  logic         cmp_wr_i,
  input  logic [W-1:0] cmp_wdata_i,
  input  logic         preload_i,
  input  logic [2:0]   mode_i,
  input  logic         chan_en_i,
  input  logic         sel_wr_i,
  input  logic [1:0]   sel_wdata_i,
  output logic         ref_o,
  output logic         match_o,
  output logic [1:0]   sel_o
);

  logic [W-1:0] cmp_act;
  chsel_e       sel_cur;

  ocx_cmp_shadow #(.W(W)) u_shadow (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_i     (cmp_wr_i),
    .wdata_i  (cmp_wdata_i),
    .preload_i(preload_i),
    .upd_i    (upd_i),
    .active_o (cmp_act)
  );

  ocx_ref_gen #(.W(W)) u_ref (
    .clk    (clk),
    .rst_n  (rst_n),
    .cnt_i  (cnt_i),
    .cmp_i  (cmp_act),
    .mode_i (ocm_e'(mode_i)),
    .ref_o  (ref_o),
    .match_o(match_o)
  );

  ocx_sel_lock u_sel (
    .clk      (clk),
    .rst_n    (rst_n),
    .chan_en_i(chan_en_i),
    .wr_i     (sel_wr_i),
    .wdata_i  (sel_wdata_i),
    .sel_o    (sel_cur)
  );

  assign sel_o = sel_cur;

endmodule

// File: rtl/ocx_channel_chk.sv
module ocx_channel_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] cnt_i,
  input logic         cmp_wr_i,
  input logic [W-1:0] cmp_wdata_i,
  input logic         preload_i,
  input logic [2:0]   mode_i,
  input logic         chan_en_i,
  input logic         ref_o,
  input logic         match_o,
  input logic [1:0]   sel_o,
  input logic [W-1:0] cmp_act
);

  assert_frozen_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b000) |=> $stable(ref_o));

  assert_force_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b100) |=> !ref_o);

  assert_force_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b101) |=> ref_o);

  assert_pwm_a_level_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b110) |=> (ref_o == $past(cnt_i < cmp_act)));

  assert_pwm_b_level_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_i == 3'b111) |=> (ref_o == !$past(cnt_i < cmp_act)));

  assert_direct_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_wr_i && !preload_i) |=> (cmp_act == $past(cmp_wdata_i)));

  assert_match_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (match_o == $past(cnt_i == cmp_act)));

  assert_sel_locked_R10: assert property (@(posedge clk) disable iff (!rst_n)
    chan_en_i |=> $stable(sel_o));

endmodule

bind ocx_channel ocx_channel_chk #(.W(W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .cnt_i      (cnt_i),
  .cmp_wr_i   (cmp_wr_i),
  .cmp_wdata_i(cmp_wdata_i),
  .preload_i  (preload_i),
  .mode_i     (mode_i),
  .chan_en_i  (chan_en_i),
  .ref_o      (ref_o),
  .match_o    (match_o),
  .sel_o      (sel_o),
  .cmp_act    (cmp_act)
);

// File: tb/ocx_channel_test.sv
`timescale 1ns/1ps
module ocx_channel_test;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [W-1:0] cnt_i;
  logic         upd_i;
  logic         cmp_wr_i;
  logic [W-1:0] cmp_wdata_i;
  logic         preload_i;
  logic [2:0]   mode_i;
  logic         chan_en_i;
  logic         sel_wr_i;
  logic [1:0]   sel_wdata_i;
  logic         ref_o;
  logic         match_o;
  logic [1:0]   sel_o;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // bench model state
  logic [W-1:0] m_hold, m_act;
  logic         m_ref, m_match;
  logic [1:0]   m_sel;
  logic [2:0]   m_mode_prev;

  always #2.5 clk = ~clk;

  ocx_channel #(.W(W)) uut (
    .clk(clk), .rst_n(rst_n), .cnt_i(cnt_i), .upd_i(upd_i),
    .cmp_wr_i(cmp_wr_i), .cmp_wdata_i(cmp_wdata_i), .preload_i(preload_i),
    .mode_i(mode_i), .chan_en_i(chan_en_i), .sel_wr_i(sel_wr_i),
    .sel_wdata_i(sel_wdata_i), .ref_o(ref_o), .match_o(match_o), .sel_o(sel_o)
  );

  function automatic string mode_tag(input logic [2:0] m);
    case (m)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R3";
      3'b011: return "R4";
      3'b100, 3'b101: return "R5";
      3'b110: return "R6";
      default: return "R7";
    endcase
  endfunction

  // Expected reference level from the requirement of each mode.
  function automatic logic exp_ref(input logic [2:0] m, input logic cur,
                                   input logic [W-1:0] c, input logic [W-1:0] a);
    case (m)
      3'b001: return (c == a) ? 1'b1 : cur;
      3'b010: return (c == a) ? 1'b0 : cur;
      3'b011: return (c == a) ? ~cur : cur;
      3'b100: return 1'b0;
      3'b101: return 1'b1;
      3'b110: return (c < a);
      3'b111: return !(c < a);
      default: return cur;
    endcase
  endfunction

  task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Drive at negedge, model at posedge, compare 1 ns after the edge.
  task automatic step(input logic [W-1:0] c, input logic u, input logic w,
                      input logic [W-1:0] wd, input logic pl, input logic [2:0] m,
                      input logic en, input logic sw, input logic [1:0] sd);
    logic [W-1:0] nact;
    @(negedge clk);
    cnt_i = c; upd_i = u; cmp_wr_i = w; cmp_wdata_i = wd; preload_i = pl;
    mode_i = m; chan_en_i = en; sel_wr_i = sw; sel_wdata_i = sd;
    @(posedge clk);
    m_ref   = exp_ref(m, m_ref, c, m_act);
    m_match = (c == m_act);
    nact = m_act;
    if (!pl) begin
      if (w) nact = wd;
    end else if (u) begin
      nact = w ? wd : m_hold;
    end
    if (w) m_hold = wd;
    m_act = nact;
    if (sw && !en) m_sel = sd;
    m_mode_prev = m;
    #1;
    check(mode_tag(m), W'(ref_o), W'(m_ref));
    check("R9 R8", W'(match_o), W'(m_match));
    check("R10", W'(sel_o), W'(m_sel));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0c11));
    rst_n = 1'b0;
    cnt_i = '0; upd_i = 0; cmp_wr_i = 0; cmp_wdata_i = '0; preload_i = 0;
    mode_i = 3'b000; chan_en_i = 0; sel_wr_i = 0; sel_wdata_i = 2'b00;
    m_hold = '0; m_act = '0; m_ref = 0; m_match = 0; m_sel = 2'b00; m_mode_prev = 3'b000;
    #12;
    // R11: reset state
    check("R11", W'(ref_o), '0);
    check("R11", W'(match_o), '0);
    check("R11", W'(sel_o), '0);
    @(negedge clk);
    rst_n = 1'b1;
    // R11: active compare is 0, so count 0 matches and count 1 does not
    step(16'd0, 0, 0, 0, 0, 3'b000, 0, 0, 0);
    check("R11", W'(match_o), W'(1));
    step(16'd1, 0, 0, 0, 0, 3'b000, 0, 0, 0);
    check("R11", W'(match_o), W'(0));

    // R8 directed: preloaded write held until update
    step(16'd0, 0, 1, 16'd5, 1, 3'b110, 0, 0, 0);
    for (int i = 0; i < 8; i++) step(W'(i), 0, 0, 0, 1, 3'b110, 0, 0, 0);
    check("R8 held", W'(ref_o), W'(0)); // count 7, compare still 0
    step(16'd9, 1, 0, 0, 1, 3'b110, 0, 0, 0);
    step(16'd4, 0, 0, 0, 1, 3'b110, 0, 0, 0);
    check("R8 loaded", W'(ref_o), W'(1)); // 4 < 5
    // R8 write and update same cycle
    step(16'd2, 1, 1, 16'd3, 1, 3'b110, 0, 0, 0);
    step(16'd3, 0, 0, 0, 1, 3'b111, 0, 0, 0);
    check("R8 same cycle", W'(match_o), W'(1));
    // R8 direct write without preload
    step(16'd0, 0, 1, 16'd9, 0, 3'b000, 0, 0, 0);
    step(16'd9, 0, 0, 0, 0, 3'b000, 0, 0, 0);
    check("R8 direct", W'(match_o), W'(1));

    // R10 directed: locked write ignored, unlocked accepted
    step(16'd0, 0, 0, 0, 0, 3'b000, 1, 1, 2'b11);
    check("R10 locked", W'(sel_o), W'(0));
    step(16'd0, 0, 0, 0, 0, 3'b000, 0, 1, 2'b10);
    check("R10 open", W'(sel_o), W'(2));

    // R4 directed: two matches toggle twice
    step(16'd9, 0, 0, 0, 0, 3'b101, 0, 0, 0);
    step(16'd9, 0, 0, 0, 0, 3'b011, 0, 0, 0);
    check("R4 first", W'(ref_o), W'(0));
    step(16'd9, 0, 0, 0, 0, 3'b011, 0, 0, 0);
    check("R4 second", W'(ref_o), W'(1));

    // Constrained random segments, one mode per segment, small count range
    for (int seg = 0; seg < 96; seg++) begin
      logic [2:0] m;
      logic       pl;
      logic [W-1:0] c;
      m  = 3'(seg % 8);
      pl = 1'($urandom_range(0, 1));
      c  = W'($urandom_range(0, 15));
      for (int k = 0; k < 40; k++) begin
        if ($urandom_range(0, 3) == 0) c = W'($urandom_range(0, 15));
        else c = (c == 15) ? '0 : c + 1'b1;
        step(c,
             1'($urandom_range(0, 9) == 0),
             1'($urandom_range(0, 7) == 0),
             W'($urandom_range(0, 16)),
             pl, m,
             1'($urandom_range(0, 1)),
             1'($urandom_range(0, 3) == 0),
             2'($urandom_range(0, 3)));
      end
    end

    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule